// File: doc/BRIEF.md
# GPIO Input Debounce Bank

This block cleans up to 32 general-purpose input pins before they reach edge and level detection. Every pin is first brought into the system clock domain by a two-flop synchronizer. After that, each pin either passes straight through or goes through its own glitch filter. A filtered pin moves its output to a new level only after two consecutive sample points have both seen that level.

Each pin picks how often its filter samples. It can sample on every system clock, which rejects only single-cycle spikes. It can also sample on a tick from one divider shared by the whole bank. The divider takes a 24-bit value D and produces one tick every D+1 clocks, so a filtered pin settles in about 2*(D+1) clocks.

All configuration arrives as plain level inputs held by surrounding register logic. After reset, every filter loads the pin's first synchronized level directly, so start-up produces no spurious transition.

Top module: `pin_debounce_bank`

## Requirements
- R1: While `rst_n` is low, every bit of `pin_o` is 0.
- R2: After `rst_n` rises, each filter takes the first synchronized pin level directly. With inputs held steady, `pin_o` equals `pin_i` from the 4th rising clock edge after release on, whatever the divider setting, and no later transition follows.
- R3: A pin whose `deb_en_i` bit is 0 passes unfiltered: `pin_o` shows a change of `pin_i` exactly 2 clock edges later (synchronizer only).
- R4: A pin with `deb_en_i`=1 and `div_sel_i`=0 samples on every clock. A held level change appears on `pin_o` exactly 4 edges after it is applied. A pulse 1 clock long never appears. A pulse 2 clocks long does appear.
- R5: The shared divider counts 0..D on the 24-bit value `div_val_i` and emits a one-clock tick at terminal count, once every D+1 clocks. A pin with `deb_en_i`=1 and `div_sel_i`=1 samples only on that tick. A held change on such a pin appears between D+4 and 2D+4 edges after it is applied.
- R6: On a divided pin, a pulse shorter than D+1 clocks is always rejected. A pulse of 3*(D+1) clocks always comes through.
- R7: Any change of `div_val_i` restarts the divider from 0 with no tick in that cycle. A divided-pin change applied in the same cycle as the new D appears exactly 2D+4 edges later.
- R8: A filtered output changes only at a sample point, and only after two consecutive sample points have both seen the new level. Between sample points it holds.
- R9: While a pin is bypassed, its filter state follows the synchronized level. Turning its debounce on then causes no transition on a steady pin, and later changes are filtered normally.
- R10: Pins are independent. Each pin's enable and divider selection affect only that pin, and the divider value is shared by all pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw asynchronous pin levels |
| deb_en_i | input | NPINS | Per-pin filter enable (0 = bypass) |
| div_sel_i | input | NPINS | Per-pin sample source (1 = divider tick, 0 = every clock) |
| div_val_i | input | DIV_W | Shared divider terminal count D |
| pin_o | output | NPINS | Synchronized, optionally filtered levels |

## Verification
Latency is counted from the falling edge where a stimulus is driven.

- **Bypassed pins** are due 2 rising edges later.
- **Every-clock filtered pins** are due 4 edges later.
- **Divided pins** fall in a window of D+4 to 2D+4 edges, which depends on the divider phase. When the stimulus arrives together with a new D, the divider phase is known, and the result is due exactly 2D+4 edges later.

The bench drives inputs on falling edges. It counts rising edges one by one and reads `pin_o` at the following falling edge, so each check compares against an exact edge count or a window bound. Glitch rejection is checked by watching the output for a fixed number of cycles after the pulse.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    // Per-pin filter state
    typedef struct packed {
        logic lvl;    // current filtered level
        logic cand;   // candidate level seen at the last sample point
        logic armed;  // one sample of the candidate already seen
    } pdb_flt_t;

endpackage

// File: rtl/pdb_sync.sv
module pdb_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            st_d[k] = st_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];

endmodule

// File: rtl/pdb_tick_gen.sv
module pdb_tick_gen #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val_i,
    output logic             tick_o,
    output logic [DIV_W-1:0] cnt_o,
    output logic [DIV_W-1:0] div_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             tick;
    } tg_state_t;

    tg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (div_val_i != st_q.div) begin
            // new terminal count: restart, no tick this cycle
            st_d.div = div_val_i;
            st_d.cnt = '0;
        end else if (st_q.cnt == st_q.div) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
    assign cnt_o  = st_q.cnt;
    assign div_o  = st_q.div;

endmodule

// File: rtl/pdb_filter.sv
module pdb_filter
    import pdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic samp,
    input  logic en,
    input  logic load,
    output logic dout
);

    pdb_flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load || !en) begin
            // track the pin so that enabling later is seamless
            st_d.lvl   = din;
            st_d.cand  = din;
            st_d.armed = 1'b0;
        end else if (samp) begin
            if (din == st_q.lvl) begin
                st_d.armed = 1'b0;
            end else if (st_q.armed && (din == st_q.cand)) begin
                st_d.lvl   = din;
                st_d.armed = 1'b0;
            end else begin
                st_d.cand  = din;
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = en ? st_q.lvl : din;

endmodule

// File: rtl/pin_debounce_bank.sv
module pin_debounce_bank #(
    parameter int NPINS       = 32,
    parameter int DIV_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] deb_en_i,
    input  logic [NPINS-1:0] div_sel_i,
    input  logic [DIV_W-1:0] div_val_i,
    output logic [NPINS-1:0] pin_o
);

    localparam int BOOT_LAST = SYNC_STAGES;
    localparam int BOOT_W    = $clog2(SYNC_STAGES + 2);

    logic [NPINS-1:0]  sync_s;
    logic [NPINS-1:0]  samp;
    logic              tick;
    logic [DIV_W-1:0]  div_cnt;
    logic [DIV_W-1:0]  div_cur;
    logic [BOOT_W-1:0] boot_d, boot_q;
    logic              load;

    // Start-up window: filters load the synchronized level directly
    assign load = (boot_q <= BOOT_W'(BOOT_LAST));

    always_comb begin
        boot_d = boot_q;
        if (load) boot_d = boot_q + BOOT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) boot_q <= '0;
        else        boot_q <= boot_d;
    end

    pdb_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_i),
        .dout  (sync_s)
    );

    pdb_tick_gen #(
        .DIV_W (DIV_W)
    ) i_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_val_i (div_val_i),
        .tick_o    (tick),
        .cnt_o     (div_cnt),
        .div_o     (div_cur)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign samp[g] = div_sel_i[g] ? tick : 1'b1;

        pdb_filter i_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (sync_s[g]),
            .samp  (samp[g]),
            .en    (deb_en_i[g]),
            .load  (load),
            .dout  (pin_o[g])
        );
    end

endmodule

// File: rtl/pdb_checker.sv
module pdb_checker #(
    parameter int NPINS = 32,
    parameter int DIV_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] deb_en_i,
    input logic [NPINS-1:0] pin_o,
    input logic [NPINS-1:0] sync_s,
    input logic [NPINS-1:0] samp,
    input logic             load,
    input logic             tick,
    input logic [DIV_W-1:0] div_cnt,
    input logic [DIV_W-1:0] div_cur,
    input logic [DIV_W-1:0] div_val_i
);

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        // R3: a bypassed pin shows the synchronizer output
        assert_bypass_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !deb_en_i[g] |-> (pin_o[g] == sync_s[g]));

        // R8: no sample point, no change of a filtered output
        assert_hold_between_samples_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (deb_en_i[g] && !load && !samp[g]) |=> (!deb_en_i[g] || $stable(pin_o[g])));
    end

    // R5: the divider count stays within 0..D
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= div_cur);

    // R5: a tick lasts one clock unless D is 0
    assert_tick_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_cur != '0)) |=> !tick);

    // R7: a new divider value restarts the count with no tick
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_val_i != div_cur) |=> ((div_cnt == '0) && !tick));

endmodule

bind pin_debounce_bank pdb_checker #(
    .NPINS (NPINS),
    .DIV_W (DIV_W)
) i_pdb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .deb_en_i  (deb_en_i),
    .pin_o     (pin_o),
    .sync_s    (sync_s),
    .samp      (samp),
    .load      (load),
    .tick      (tick),
    .div_cnt   (div_cnt),
    .div_cur   (div_cur),
    .div_val_i (div_val_i)
);

// File: tb/test_pin_debounce_bank.sv
module test_pin_debounce_bank;

    localparam int NPINS = 32;
    localparam int DIV_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NPINS-1:0] pin_i = '0;
    logic [NPINS-1:0] deb_en_i = '1;
    logic [NPINS-1:0] div_sel_i = '1;
    logic [DIV_W-1:0] div_val_i = '0;
    logic [NPINS-1:0] pin_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    localparam logic [31:0] RST_PAT = 32'hA5A5_0000;

    always #4 clk = ~clk;  // 125 MHz

    pin_debounce_bank #(
        .NPINS (NPINS),
        .DIV_W (DIV_W)
    ) i_pin_debounce_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .deb_en_i  (deb_en_i),
        .div_sel_i (div_sel_i),
        .div_val_i (div_val_i),
        .pin_o     (pin_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_range(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    // n rising edges, then settle at the following falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // edges until pin_o[idx] changes (-1 if not within limit)
    task automatic measure(input int idx, input int limit, output int lat);
        logic old;
        old = pin_o[idx];
        lat = -1;
        for (int k = 1; k <= limit; k++) begin
            step(1);
            if (pin_o[idx] !== old && lat < 0) lat = k;
        end
    endtask

    // count high and low observations of pin_o[idx] over n cycles
    task automatic watch(input int idx, input int n, output int n_hi, output int n_lo);
        n_hi = 0;
        n_lo = 0;
        for (int k = 0; k < n; k++) begin
            step(1);
            if (pin_o[idx]) n_hi++;
            else            n_lo++;
        end
    endtask

    task automatic t_reset();
        int changes;
        pin_i     = RST_PAT;
        deb_en_i  = '1;
        div_sel_i = '1;
        div_val_i = 24'd1000;
        step(5);
        chk("R1 outputs low in reset", pin_o, 32'h0);
        rst_n = 1'b1;
        step(4);
        chk("R2 load after reset", pin_o, RST_PAT);
        changes = 0;
        for (int k = 0; k < 30; k++) begin
            step(1);
            if (pin_o !== RST_PAT) changes++;
        end
        chk("R2 no later transition", 32'(changes), 32'd0);
    endtask

    task automatic t_bypass();
        int lat;
        deb_en_i[4] = 1'b0;
        step(3);
        pin_i[4] = 1'b1;
        measure(4, 8, lat);
        chk("R3 bypass rise latency", 32'(lat), 32'd2);
        pin_i[4] = 1'b0;
        measure(4, 8, lat);
        chk("R3 bypass fall latency", 32'(lat), 32'd2);
    endtask

    task automatic t_undivided();
        int lat, hi, lo;
        deb_en_i[6]  = 1'b1;
        div_sel_i[6] = 1'b0;
        step(3);
        pin_i[6] = 1'b1;
        measure(6, 10, lat);
        chk("R4 every-clock rise latency", 32'(lat), 32'd4);
        pin_i[6] = 1'b0;
        measure(6, 10, lat);
        chk("R4 every-clock fall latency", 32'(lat), 32'd4);
        pin_i[6] = 1'b1;
        step(1);
        pin_i[6] = 1'b0;
        watch(6, 12, hi, lo);
        chk("R4 one-clock pulse rejected", 32'(hi), 32'd0);
        pin_i[6] = 1'b1;
        step(2);
        pin_i[6] = 1'b0;
        watch(6, 12, hi, lo);
        chk("R4 two-clock pulse passes R8", 32'(hi > 0), 32'd1);
        chk("R4 returns low", 32'(pin_o[6]), 32'd0);
    endtask

    task automatic t_divided();
        int lat;
        div_val_i    = 24'd3;
        deb_en_i[7]  = 1'b1;
        div_sel_i[7] = 1'b1;
        step(20);
        for (int ph = 0; ph < 4; ph++) begin
            step(ph);
            pin_i[7] = ~pin_i[7];
            measure(7, 16, lat);
            chk_range("R5 R8 divided latency", lat, 3 + 4, 2 * 3 + 4);
        end
    endtask

    task automatic t_restart();
        int lat;
        deb_en_i[8]  = 1'b1;
        div_sel_i[8] = 1'b1;
        step(10);
        div_val_i = 24'd5;
        pin_i[8]  = 1'b1;
        measure(8, 20, lat);
        chk("R7 restart exact latency", 32'(lat), 32'd14);
    endtask

    task automatic t_div_glitch();
        int hi, lo;
        div_val_i    = 24'd7;
        deb_en_i[9]  = 1'b1;
        div_sel_i[9] = 1'b1;
        step(20);
        for (int ph = 0; ph < 3; ph++) begin
            step(ph);
            pin_i[9] = 1'b1;
            step(7);
            pin_i[9] = 1'b0;
            watch(9, 40, hi, lo);
            chk("R6 short pulse rejected", 32'(hi), 32'd0);
        end
        pin_i[9] = 1'b1;
        watch(9, 24, hi, lo);
        pin_i[9] = 1'b0;
        chk("R6 long pulse passes", 32'(hi > 0), 32'd1);
        watch(9, 30, hi, lo);
        chk("R6 long pulse ends low", 32'(pin_o[9]), 32'd0);
    endtask

    task automatic t_enable_switch();
        int hi, lo, lat;
        deb_en_i[10]  = 1'b0;
        div_sel_i[10] = 1'b1;
        step(2);
        pin_i[10] = 1'b1;
        step(6);
        deb_en_i[10] = 1'b1;
        watch(10, 20, hi, lo);
        chk("R9 enable causes no transition", 32'(lo), 32'd0);
        pin_i[10] = 1'b0;
        measure(10, 24, lat);
        chk_range("R9 filtered after enable", lat, 7 + 4, 2 * 7 + 4);
    endtask

    task automatic t_independent();
        logic [31:0] upper;
        deb_en_i[11] = 1'b0;
        deb_en_i[12] = 1'b1; div_sel_i[12] = 1'b0;
        deb_en_i[13] = 1'b1; div_sel_i[13] = 1'b1;
        step(20);
        upper = {pin_o[31:14], 14'h0};
        pin_i[13:11] = 3'b111;
        step(2);
        chk("R10 at edge 2", 32'(pin_o[13:11]), 32'b001);
        step(1);
        chk("R10 at edge 3", 32'(pin_o[13:11]), 32'b001);
        step(1);
        chk("R10 at edge 4", 32'(pin_o[13:11]), 32'b011);
        step(6);
        chk("R10 at edge 10", 32'(pin_o[13:11]), 32'b011);
        step(9);
        chk("R10 at edge 19", 32'(pin_o[13:11]), 32'b111);
        chk("R10 other pins untouched", {pin_o[31:14], 14'h0}, upper);
        chk("R10 other pins match inputs", {pin_o[31:14], 14'h0}, {RST_PAT[31:14], 14'h0});
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_undivided();
        t_divided();
        t_restart();
        t_div_glitch();
        t_enable_switch();
        t_independent();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule